// File: doc/BRIEF.md
# Three-pin bidirectional I/O port with analog override

This block is a small general-purpose I/O port of three pins, controlled through a simple register bus with a two-bit address, a one-cycle write strobe and combinational read data. Each pin has a direction bit and an output data bit. The port drives a per-pin output value and output enable towards a tristate pad wrapper. It samples the pad inputs through a synchronizer.

Software can read back the pin levels at one address and the held output values at another. Read-modify-write sequences on the output-value address therefore act on the values software intends to drive, whatever the pads show. A separate per-pin analog-select input marks pins handed to an analog converter. Such pins read as zero on the digital path. Their output driver is still governed only by the direction bit.

Address map: 0 reads the synchronized pin levels and writes the output values. 1 reads and writes the output values. 2 reads and writes the direction bits. 3 is unused.

Top module: `gpio_trio_port`

## Requirements
- R1: After reset the direction bits are all 1 (every `pin_oe` bit low) and the output values are all 0. A read at address 2 returns 7 and a read at address 1 returns 0.
- R2: For each pin, `pin_oe` is the inverse of its direction bit: 1 means input with the driver off, and 0 means driving. `pin_out` always carries that pin's output value bit.
- R3: A write strobe at address 0 or address 1 loads `bus_wdata[2:0]` into the output values, visible on `pin_out` after the clock edge that samples the strobe.
- R4: A write strobe at address 2 loads `bus_wdata[2:0]` into the direction bits, visible on `pin_oe` and in reads at address 2 after that edge.
- R5: A read at address 1 returns the held output values, even when the pin levels differ from them.
- R6: A read at address 0 returns `pin_in` as it was two clock edges earlier, after passing through a two-stage synchronizer.
- R7: At address 0, every bit whose `ana_sel` bit is 1 reads as 0.
- R8: `ana_sel` has no effect on `pin_oe` or `pin_out`.
- R9: Read data bits 7 to 3 are always 0. A read at address 3 returns 0, and a write at address 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ana_sel | input | 3 | Per-pin analog selection, 1 = analog |
| pin_in | input | 3 | Pad input levels |
| pin_out | output | 3 | Per-pin output value to the pad |
| pin_oe | output | 3 | Per-pin output enable, 1 = drive |

## Verification
Register writes take effect one edge after the strobe. The bench therefore raises the strobe at a falling edge and checks `pin_out`, `pin_oe` and the read-back at the next falling edge, after exactly one rising edge has passed. Pin levels reach address 0 two rising edges after they change. For each new pattern, the bench checks at the first falling edge that the previous pattern is still shown, and at the second that the new one has arrived. Reads and the `ana_sel` mask are combinational, so the bench samples them a short delay after setting the address, away from any edge.

// File: rtl/gpio_trio_pkg.sv
package gpio_trio_pkg;
   localparam int unsigned ADDR_W = 2;
   typedef enum logic [ADDR_W-1:0] {
      SEL_PIN  = 2'd0,
      SEL_OUT  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_trio_pkg::*;
#(
   parameter int unsigned NPIN = 3,
   parameter int unsigned DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic            wr,
   input  logic [DW-1:0]   wdata,
   output logic [NPIN-1:0] lat_q,
   output logic [NPIN-1:0] dir_q
);
   logic unused_hi;
   assign unused_hi = ^wdata;

   logic hit_out, hit_dir;
   assign hit_out = wr && (addr == SEL_PIN || addr == SEL_OUT);
   assign hit_dir = wr && (addr == SEL_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '1;
      end else begin
         if (hit_out) lat_q <= wdata[NPIN-1:0];
         if (hit_dir) dir_q <= wdata[NPIN-1:0];
      end
   end
endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
   import gpio_trio_pkg::*;
#(
   parameter int unsigned NPIN = 3,
   parameter int unsigned DW   = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NPIN-1:0] pin_s,
   input  logic [NPIN-1:0] ana_sel,
   input  logic [NPIN-1:0] lat_q,
   input  logic [NPIN-1:0] dir_q,
   output logic [DW-1:0]   rdata
);
   always_comb begin
      rdata = '0;
      unique case (reg_sel_e'(addr))
         SEL_PIN:  rdata[NPIN-1:0] = pin_s & ~ana_sel;
         SEL_OUT:  rdata[NPIN-1:0] = lat_q;
         SEL_DIR:  rdata[NPIN-1:0] = dir_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_trio_port.sv
module gpio_trio_port
   import gpio_trio_pkg::*;
#(
   parameter int unsigned NPIN        = 3,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic [DW-1:0]       bus_wdata,
   output logic [DW-1:0]       bus_rdata,
   input  logic [NPIN-1:0]     ana_sel,
   input  logic [NPIN-1:0]     pin_in,
   output logic [NPIN-1:0]     pin_out,
   output logic [NPIN-1:0]     pin_oe
);
   if (NPIN == 0 || NPIN > DW) begin : g_bad_width
      $error("gpio_trio_port: NPIN must be between 1 and DW");
   end
   if (SYNC_STAGES == 1) begin : g_bad_sync
      $error("gpio_trio_port: SYNC_STAGES must be 0 or at least 2");
   end

   logic [NPIN-1:0] pin_s, lat_q, dir_q;

   gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
   );

   gpio_regs #(.NPIN(NPIN), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata), .lat_q(lat_q), .dir_q(dir_q)
   );

   gpio_rdmux #(.NPIN(NPIN), .DW(DW)) u_rd (
      .addr(bus_addr), .pin_s(pin_s), .ana_sel(ana_sel),
      .lat_q(lat_q), .dir_q(dir_q), .rdata(bus_rdata)
   );

   assign pin_out = lat_q;
   assign pin_oe  = ~dir_q;
endmodule

// File: rtl/gpio_trio_port_chk.sv
module gpio_trio_port_chk #(
   parameter int unsigned NPIN = 3,
   parameter int unsigned DW   = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic [1:0]      bus_addr,
   input logic            bus_wr,
   input logic [DW-1:0]   bus_wdata,
   input logic [DW-1:0]   bus_rdata,
   input logic [NPIN-1:0] ana_sel,
   input logic [NPIN-1:0] pin_in,
   input logic [NPIN-1:0] pin_out,
   input logic [NPIN-1:0] pin_oe
);
   logic [1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_cnt <= '0;
      else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
   end

   // R3
   a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr <= 2'd1) |=> pin_out == $past(bus_wdata[NPIN-1:0]));
   // R4
   a_r4_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2) |=> pin_oe == ~$past(bus_wdata[NPIN-1:0]));
   // R2
   a_r2_oe_vs_dir_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == 2'd2 |-> bus_rdata[NPIN-1:0] == ~pin_oe);
   // R5
   a_r5_latch_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == 2'd1 |-> bus_rdata[NPIN-1:0] == pin_out);
   // R6
   a_r6_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd0 && ana_sel == '0 && run_cnt >= 2'd2)
      |-> bus_rdata[NPIN-1:0] == $past(pin_in, 2));
   // R7
   a_r7_analog_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr == 2'd0 |-> (bus_rdata[NPIN-1:0] & ana_sel) == '0);
   // R9
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DW-1:NPIN] == '0);
   // R9
   a_r9_hole_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd3) |=> $stable(pin_out) && $stable(pin_oe));
endmodule

bind gpio_trio_port gpio_trio_port_chk #(.NPIN(NPIN), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
   .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_trio_port.sv
module sim_gpio_trio_port;
   localparam int PERIOD = 10;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [1:0] bus_addr = 0;
   logic       bus_wr = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata;
   logic [2:0] ana_sel = 3'b111;
   logic [2:0] pin_in = 0;
   logic [2:0] pin_out, pin_oe;

   int n_cmp = 0;
   int n_bad = 0;

   always #(PERIOD/2) clk = ~clk;

   gpio_trio_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      logic [7:0] r;
      logic [2:0] prev;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd2, r); check("R1 dir reset", r, 8'd7);
      rd(2'd1, r); check("R1 latch reset", r, 8'd0);
      check("R1 oe reset", {5'd0, pin_oe}, 8'd0);
      rst_n = 1;
      @(negedge clk);

      // R3 writes via address 0 and address 1, all values
      for (int v = 0; v < 8; v++) begin
         wr(2'd0, 8'hF8 | v[7:0]);
         check("R3 addr0 pin_out", {5'd0, pin_out}, v[7:0]);
         wr(2'd1, {5'b10101, ~v[2:0]});
         check("R3 addr1 pin_out", {5'd0, pin_out}, {5'd0, ~v[2:0]});
         rd(2'd1, r); check("R9 latch read upper zero", r, {5'd0, ~v[2:0]});
      end

      // R4 and R2: direction sweep
      for (int v = 0; v < 8; v++) begin
         wr(2'd2, 8'hE0 | v[7:0]);
         check("R2 oe inverse of dir", {5'd0, pin_oe}, {5'd0, ~v[2:0]});
         rd(2'd2, r); check("R4 dir readback", r, v[7:0]);
      end

      // R5: latch read independent of pins
      wr(2'd2, 8'd0);
      wr(2'd1, 8'd5);
      ana_sel = 3'b000;
      pin_in = 3'd2;
      repeat (3) @(negedge clk);
      rd(2'd1, r); check("R5 latch not pin", r, 8'd5);
      rd(2'd0, r); check("R6 pin level", r, 8'd2);

      // R8: analog select leaves the driver alone
      for (int a = 0; a < 8; a++) begin
         ana_sel = a[2:0];
         #1;
         check("R8 oe unaffected", {5'd0, pin_oe}, 8'd7);
         check("R8 out unaffected", {5'd0, pin_out}, 8'd5);
      end

      // R6 and R7: pin / analog sweep
      wr(2'd2, 8'd7);
      prev = pin_in;
      for (int p = 0; p < 8; p++) begin
         for (int a = 0; a < 8; a++) begin
            logic [2:0] nv;
            nv = p[2:0] ^ a[2:0] ^ 3'b101;
            @(negedge clk);
            ana_sel = a[2:0];
            pin_in = nv;
            @(negedge clk);
            rd(2'd0, r); check("R6 one edge old", r, {5'd0, prev & ~a[2:0]});
            @(negedge clk);
            rd(2'd0, r); check("R7 masked pin read", r, {5'd0, nv & ~a[2:0]});
            prev = nv;
         end
      end

      // R9: unused address
      wr(2'd1, 8'd3);
      wr(2'd2, 8'd6);
      wr(2'd3, 8'hFF);
      rd(2'd3, r); check("R9 addr3 reads zero", r, 8'd0);
      rd(2'd1, r); check("R9 latch kept", r, 8'd3);
      rd(2'd2, r); check("R9 dir kept", r, 8'd6);
      check("R9 oe kept", {5'd0, pin_oe}, 8'd1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 100000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule